// File: doc/BRIEF.md
# Delayed-Read Retry Controller

This block decides, cycle by cycle, how a bus target answers a read access from an external master. The application back end fills a read-data FIFO. The controller only sees whether that FIFO holds an element. On each access it chooses one of four answers: insert a wait state, hand over a data element, retry the master, or disconnect. It also tracks whether the pending read has gone into delayed mode.

A fresh read that finds the FIFO empty gets a limited run of wait states, either 16 or 32 as set by a static configuration pin. If no data arrives in that window, the controller retries the master and marks the read as delayed. While the read is delayed, an access that finds the FIFO empty is retried at once, with no wait states. The application can also force delayed mode through a request pin. When data is available, a memory read streams elements until the FIFO runs dry or the master signals its last element. An I/O read always hands over exactly one element and disconnects with it. The delayed marker is cleared once a read completes with data.

Top module: `drc_read_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_wait`, `rd_retry`, `rd_data`, `rd_disc` and `dly_active` are all 0.
- R2: An accepted memory access (`acc_is_io`=0) that finds `fifo_valid`=1 answers with `rd_data`=1 in the next cycle. It keeps giving one element per cycle while `fifo_valid`=1 and `acc_end`=0.
- R3: While a memory read streams, a cycle with `fifo_valid`=1 and `acc_end`=1 gives its last element together with `rd_disc`=1. A cycle with `fifo_valid`=0 gives `rd_disc`=1 with `rd_data`=0. Either way the access ends.
- R4: An I/O access (`acc_is_io`=1) that gets data answers with `rd_data`=1 and `rd_disc`=1 in the same cycle, exactly once.
- R5: An accepted access that finds the FIFO empty while `dly_active`=1 or `dly_req`=1 answers with `rd_retry`=1 in the next cycle and inserts no wait state.
- R6: An accepted access that finds the FIFO empty outside delayed mode gets wait states (`rd_wait`=1), at most N of them in a row. N is 16 when `cfg_long_wait` was 0 during reset, and 32 when it was 1. If the FIFO is still empty after the N-th wait, the next cycle gives `rd_retry`=1.
- R7: Every retry sets `dly_active` to 1 in the same cycle that `rd_retry` is 1.
- R8: `dly_req`=1 in any cycle makes `dly_active` 1 in the next cycle.
- R9: A read that ends with a disconnect after delivering data clears `dly_active`, unless `dly_req` is 1 in the same cycle.
- R10: `acc_start` is ignored while an access is in progress, that is, while waiting or streaming.
- R11: If data reaches the FIFO during the wait states, the next cycle gives `rd_data`=1 and no retry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_long_wait | input | 1 | Wait budget select, sampled during reset: 0 gives 16 waits, 1 gives 32 |
| acc_start | input | 1 | Master begins a read access this cycle |
| acc_is_io | input | 1 | Command type of the access: 1 = I/O read, 0 = memory read |
| acc_end | input | 1 | Master takes its last element this cycle |
| dly_req | input | 1 | Request to put the read into delayed mode |
| fifo_valid | input | 1 | Read FIFO holds at least one element |
| rd_wait | output | 1 | Insert a wait state |
| rd_retry | output | 1 | Retry the master |
| rd_data | output | 1 | Hand over (pop) one FIFO element |
| rd_disc | output | 1 | Disconnect (with data when `rd_data` is also 1) |
| dly_active | output | 1 | The pending read is in delayed mode |

## Verification
Suppose the delayed marker is wrong. If it is stuck high, the very next empty access is retried instead of receiving a wait state. If it is stuck low, a repeated empty poll starts a fresh run of waits. Both show at the ports one cycle after `acc_start`. A wait counter that is off by one, or a budget latched from the wrong value, changes the length of the wait run. That error shows up as a `rd_retry` one cycle early or late, relative to the 16th or 32nd wait. A lost access type shows as a second `rd_data` on an I/O read, or as a missing `rd_disc` beside its first element.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STREAM = 2'd2
  } drc_state_e;

  typedef struct packed {
    logic hold;
    logic retry;
    logic data;
    logic disc;
  } drc_resp_t;
endpackage

// File: rtl/drc_wait_timer.sv
module drc_wait_timer #(
  parameter int SHORT_WAITS = 16,
  parameter int LONG_WAITS  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_long,
  input  logic load,
  input  logic inc,
  output logic at_limit
);
  localparam int CNT_W = $clog2(LONG_WAITS + 1);

  logic [CNT_W-1:0] budget_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      budget_q <= cfg_long ? CNT_W'(LONG_WAITS) : CNT_W'(SHORT_WAITS);
      cnt_q    <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(1);
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign at_limit = (cnt_q >= budget_q);
endmodule

// File: rtl/drc_delay_flag.sv
module drc_delay_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic set_retry,
  input  logic clr_done,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                       flag <= 1'b0;
    else if (set_req || set_retry) flag <= 1'b1;
    else if (clr_done)             flag <= 1'b0;
  end
endmodule

// File: rtl/drc_seq.sv
module drc_seq
  import drc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      acc_start,
  input  logic      acc_is_io,
  input  logic      acc_end,
  input  logic      fifo_valid,
  input  logic      dly_now,
  input  logic      at_limit,
  output logic      tmr_load,
  output logic      tmr_inc,
  output logic      retry_ev,
  output logic      done_ev,
  output drc_resp_t resp_q
);
  drc_state_e state_q, state_d;
  drc_resp_t  resp_d;
  logic       io_q, io_d;

  always_comb begin
    state_d  = state_q;
    io_d     = io_q;
    resp_d   = '0;
    tmr_load = 1'b0;
    tmr_inc  = 1'b0;
    retry_ev = 1'b0;
    done_ev  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_start) begin
          io_d = acc_is_io;
          if (fifo_valid) begin
            resp_d.data = 1'b1;
            if (acc_is_io || acc_end) begin
              resp_d.disc = 1'b1;
              done_ev     = 1'b1;
            end else begin
              state_d = ST_STREAM;
            end
          end else if (dly_now) begin
            resp_d.retry = 1'b1;
            retry_ev     = 1'b1;
          end else begin
            resp_d.hold = 1'b1;
            tmr_load    = 1'b1;
            state_d     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (fifo_valid) begin
          resp_d.data = 1'b1;
          if (io_q || acc_end) begin
            resp_d.disc = 1'b1;
            done_ev     = 1'b1;
            state_d     = ST_IDLE;
          end else begin
            state_d = ST_STREAM;
          end
        end else if (at_limit) begin
          resp_d.retry = 1'b1;
          retry_ev     = 1'b1;
          state_d      = ST_IDLE;
        end else begin
          resp_d.hold = 1'b1;
          tmr_inc     = 1'b1;
        end
      end
      ST_STREAM: begin
        if (fifo_valid) begin
          resp_d.data = 1'b1;
          if (acc_end) begin
            resp_d.disc = 1'b1;
            done_ev     = 1'b1;
            state_d     = ST_IDLE;
          end
        end else begin
          resp_d.disc = 1'b1;
          done_ev     = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      io_q    <= 1'b0;
      resp_q  <= '0;
    end else begin
      state_q <= state_d;
      io_q    <= io_d;
      resp_q  <= resp_d;
    end
  end
endmodule

// File: rtl/drc_read_ctrl.sv
module drc_read_ctrl
  import drc_pkg::*;
#(
  parameter int SHORT_WAITS = 16,
  parameter int LONG_WAITS  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_long_wait,
  input  logic acc_start,
  input  logic acc_is_io,
  input  logic acc_end,
  input  logic dly_req,
  input  logic fifo_valid,
  output logic rd_wait,
  output logic rd_retry,
  output logic rd_data,
  output logic rd_disc,
  output logic dly_active
);
  logic      tmr_load, tmr_inc, at_limit;
  logic      retry_ev, done_ev;
  drc_resp_t resp;

  drc_wait_timer #(
    .SHORT_WAITS(SHORT_WAITS),
    .LONG_WAITS (LONG_WAITS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cfg_long (cfg_long_wait),
    .load     (tmr_load),
    .inc      (tmr_inc),
    .at_limit (at_limit)
  );

  drc_delay_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .set_req   (dly_req),
    .set_retry (retry_ev),
    .clr_done  (done_ev),
    .flag      (dly_active)
  );

  drc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .acc_start  (acc_start),
    .acc_is_io  (acc_is_io),
    .acc_end    (acc_end),
    .fifo_valid (fifo_valid),
    .dly_now    (dly_active | dly_req),
    .at_limit   (at_limit),
    .tmr_load   (tmr_load),
    .tmr_inc    (tmr_inc),
    .retry_ev   (retry_ev),
    .done_ev    (done_ev),
    .resp_q     (resp)
  );

  assign rd_wait  = resp.hold;
  assign rd_retry = resp.retry;
  assign rd_data  = resp.data;
  assign rd_disc  = resp.disc;
endmodule

// File: rtl/drc_read_ctrl_chk.sv
module drc_read_ctrl_chk #(
  parameter int SHORT_WAITS = 16,
  parameter int LONG_WAITS  = 32
) (
  input logic clk,
  input logic rst,
  input logic cfg_long_wait,
  input logic acc_start,
  input logic acc_is_io,
  input logic acc_end,
  input logic dly_req,
  input logic fifo_valid,
  input logic rd_wait,
  input logic rd_retry,
  input logic rd_data,
  input logic rd_disc,
  input logic dly_active
);
  logic        idle_c, io_c;
  logic [15:0] wait_run, budget_c;

  assign idle_c = !(rd_wait || (rd_data && !rd_disc));

  always_ff @(posedge clk) begin
    if (rst) begin
      budget_c <= cfg_long_wait ? 16'(LONG_WAITS) : 16'(SHORT_WAITS);
      wait_run <= '0;
      io_c     <= 1'b0;
    end else begin
      wait_run <= rd_wait ? wait_run + 16'd1 : 16'd0;
      if (acc_start && idle_c) io_c <= acc_is_io;
    end
  end

  AST_START_DATA: assert property (@(posedge clk) disable iff (rst)
    idle_c && acc_start && fifo_valid |=> rd_data); // R2
  AST_LONE_DISC: assert property (@(posedge clk) disable iff (rst)
    rd_disc && !rd_data |-> $past(rd_data)); // R3
  AST_IO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_data && io_c |-> rd_disc); // R4
  AST_DLY_EMPTY_RETRY: assert property (@(posedge clk) disable iff (rst)
    idle_c && acc_start && !fifo_valid && (dly_active || dly_req) |=> rd_retry && !rd_wait); // R5
  AST_WAIT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    wait_run <= budget_c); // R6
  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_wait, rd_retry, rd_data})); // R6
  AST_RETRY_MARKS_DLY: assert property (@(posedge clk) disable iff (rst)
    rd_retry |-> dly_active); // R7
  AST_REQ_SETS_DLY: assert property (@(posedge clk) disable iff (rst)
    dly_req |=> dly_active); // R8
endmodule

bind drc_read_ctrl drc_read_ctrl_chk #(
  .SHORT_WAITS(SHORT_WAITS),
  .LONG_WAITS (LONG_WAITS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_long_wait(cfg_long_wait), .acc_start(acc_start),
  .acc_is_io(acc_is_io), .acc_end(acc_end), .dly_req(dly_req), .fifo_valid(fifo_valid),
  .rd_wait(rd_wait), .rd_retry(rd_retry), .rd_data(rd_data), .rd_disc(rd_disc),
  .dly_active(dly_active)
);

// File: tb/drc_read_ctrl_bench.sv
module drc_read_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_long_wait = 1'b0;
  logic acc_start = 1'b0, acc_is_io = 1'b0, acc_end = 1'b0;
  logic dly_req = 1'b0, fifo_valid = 1'b0;
  logic rd_wait, rd_retry, rd_data, rd_disc, dly_active;

  always #2 clk = ~clk;

  drc_read_ctrl u_drc_read_ctrl (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Behavioural reference model: 0 idle, 1 waiting, 2 streaming
  int m_state = 0, m_cnt = 0, m_budget = 16;
  bit m_io = 0, m_dly = 0;
  bit e_wait = 0, e_retry = 0, e_data = 0, e_disc = 0;

  always @(posedge clk) begin
    bit set, clr, dnow;
    if (rst) begin
      m_state = 0; m_cnt = 0; m_dly = 0;
      m_budget = cfg_long_wait ? 32 : 16;
      {e_wait, e_retry, e_data, e_disc} = 4'b0;
    end else begin
      {e_wait, e_retry, e_data, e_disc} = 4'b0;
      set = dly_req; clr = 0; dnow = m_dly || dly_req;
      if (m_state == 0) begin
        if (acc_start) begin
          m_io = acc_is_io;
          if (fifo_valid) begin
            e_data = 1;
            if (acc_is_io || acc_end) begin e_disc = 1; clr = 1; end
            else m_state = 2;
          end else if (dnow) begin
            e_retry = 1; set = 1;
          end else begin
            e_wait = 1; m_cnt = 1; m_state = 1;
          end
        end
      end else if (m_state == 1) begin
        if (fifo_valid) begin
          e_data = 1;
          if (m_io || acc_end) begin e_disc = 1; clr = 1; m_state = 0; end
          else m_state = 2;
        end else if (m_cnt >= m_budget) begin
          e_retry = 1; set = 1; m_state = 0;
        end else begin
          e_wait = 1; m_cnt++;
        end
      end else begin
        if (fifo_valid) begin
          e_data = 1;
          if (acc_end) begin e_disc = 1; clr = 1; m_state = 0; end
        end else begin
          e_disc = 1; clr = 1; m_state = 0;
        end
      end
      if (set) m_dly = 1; else if (clr) m_dly = 0;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  int run_w = 0, last_run = 0;
  always @(negedge clk) begin
    check(cur_req, {3'b0, rd_wait, rd_retry, rd_data, rd_disc, dly_active},
          {3'b0, e_wait, e_retry, e_data, e_disc, m_dly});
    if (rd_wait) run_w++;
    else begin
      if (run_w > 0) last_run = run_w;
      run_w = 0;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(bit io);
    acc_start = 1'b1; acc_is_io = io;
    cyc(1);
    acc_start = 1'b0; acc_is_io = 1'b0;
  endtask

  task automatic do_reset(bit lng);
    rst = 1'b1; cfg_long_wait = lng;
    cyc(3);
    check("R1", {3'b0, rd_wait, rd_retry, rd_data, rd_disc, dly_active}, 8'h0);
    rst = 1'b0;
    cyc(1);
    check("R1", {3'b0, rd_wait, rd_retry, rd_data, rd_disc, dly_active}, 8'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(1);
    do_reset(1'b0);

    cur_req = "R2"; fifo_valid = 1'b1; start(1'b0); cyc(3);
    cur_req = "R3"; acc_end = 1'b1; cyc(1); acc_end = 1'b0; fifo_valid = 1'b0; cyc(2);

    cur_req = "R3"; fifo_valid = 1'b1; start(1'b0); cyc(2); fifo_valid = 1'b0; cyc(3);

    cur_req = "R4"; fifo_valid = 1'b1; start(1'b1); cyc(3);
    cur_req = "R10"; start(1'b0); start(1'b1); cyc(1);
    acc_end = 1'b1; cyc(1); acc_end = 1'b0; fifo_valid = 1'b0; cyc(2);

    cur_req = "R6"; start(1'b0); cyc(22);
    check("R6", 8'(last_run), 8'd16);
    check("R7", {7'b0, dly_active}, 8'd1);

    cur_req = "R5"; start(1'b0); cyc(3);
    check("R5", {7'b0, dly_active}, 8'd1);

    cur_req = "R9"; fifo_valid = 1'b1; start(1'b0); cyc(1);
    acc_end = 1'b1; cyc(1); acc_end = 1'b0; fifo_valid = 1'b0; cyc(1);
    check("R9", {7'b0, dly_active}, 8'd0);

    cur_req = "R8"; dly_req = 1'b1; cyc(1); dly_req = 1'b0;
    check("R8", {7'b0, dly_active}, 8'd1);
    start(1'b0); cyc(2);
    fifo_valid = 1'b1; start(1'b1); fifo_valid = 1'b0; cyc(2);
    check("R9", {7'b0, dly_active}, 8'd0);

    cur_req = "R11"; start(1'b0); cyc(5);
    fifo_valid = 1'b1; acc_end = 1'b1; cyc(1);
    fifo_valid = 1'b0; acc_end = 1'b0; cyc(3);
    check("R11", {7'b0, dly_active}, 8'd0);

    cur_req = "R8"; dly_req = 1'b1; start(1'b0); dly_req = 1'b0; cyc(2);

    cur_req = "R1"; do_reset(1'b1);
    cur_req = "R6"; start(1'b0); cyc(38);
    check("R6", 8'(last_run), 8'd32);
    check("R7", {7'b0, dly_active}, 8'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule